// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links an A bus and a B bus. The default build is 16 bits wide and made of two 8-bit halves. Each half has its own controls. An active-low enable and a direction bit decide which of the two buses the half drives. A per-direction select chooses what is driven: either the live value from the opposite bus, or a value stored earlier. Each direction has its own storage register. That register loads the opposite bus's input on a system clock edge whenever its capture strobe is high.

The pins are split into an input vector, an output vector and per-half output enables for each bus, so that pad logic outside the block forms the tri-state drivers. A bus whose output is disabled still feeds its input path, so captures go on while the half is isolated. When `gang_i` is set, the controls of half 0 govern every half, and the unit behaves as one full-width transceiver.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On a rising `clk_i` edge, a half's A-to-B register loads that half's slice of `a_i` when the effective `cap_ab` strobe is 1. Likewise, the B-to-A register loads the `b_i` slice when the effective `cap_ba` strobe is 1.
- R2: A register whose strobe is 0 keeps its value. An active-low asynchronous `rst_ni` clears every register to zero.
- R3: For each half, with effective enable `oe_n`=0: direction 1 asserts `b_oe_o` and direction 0 asserts `a_oe_o`. With `oe_n`=1 neither is asserted.
- R4: `a_oe_o[h]` and `b_oe_o[h]` are never both 1.
- R5: While `b_oe_o[h]` is 1, the B output slice equals the live `a_i` slice in the same cycle when `sel_ab`=0. It equals the A-to-B register when `sel_ab`=1.
- R6: While `a_oe_o[h]` is 1, the A output slice equals the live `b_i` slice when `sel_ba`=0. It equals the B-to-A register when `sel_ba`=1.
- R7: A bus slice whose enable is 0 outputs all zeros.
- R8: Captures in both directions take effect while the half is isolated (`oe_n`=1), and the stored values are later readable through R5 and R6.
- R9: With `gang_i`=0, each half uses only its own bit of `oe_ni`, `dir_i`, `sel_ab_i`, `sel_ba_i`, `cap_ab_i` and `cap_ba_i`.
- R10: With `gang_i`=1, bit 0 of every control input governs all halves, and the upper control bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gang_i | input | 1 | 1: half 0 controls all halves |
| oe_ni | input | NUM_HALVES | Active-low output enable per half |
| dir_i | input | NUM_HALVES | 1: drive B from A, 0: drive A from B |
| sel_ab_i | input | NUM_HALVES | B source: 0 live A, 1 stored |
| sel_ba_i | input | NUM_HALVES | A source: 0 live B, 1 stored |
| cap_ab_i | input | NUM_HALVES | Load A-to-B register |
| cap_ba_i | input | NUM_HALVES | Load B-to-A register |
| a_i | input | HALF_W*NUM_HALVES | A bus input |
| b_i | input | HALF_W*NUM_HALVES | B bus input |
| a_o | output | HALF_W*NUM_HALVES | A bus output data |
| a_oe_o | output | NUM_HALVES | A bus output enable per half |
| b_o | output | HALF_W*NUM_HALVES | B bus output data |
| b_oe_o | output | NUM_HALVES | B bus output enable per half |

## Verification
The following are checked on every cycle while the half is ungated:
- the two enables of a half are never both set;
- isolation drops both enables;
- disabled outputs read zero;
- a live selection passes the opposite input through in the same cycle;
- a strobed capture lands in the register one edge later, and an unstrobed register stays unchanged;
- under gang mode, every half follows half 0.

Other behaviours only show up in the bench's scenarios, which sweep every control combination against a reference model:
- stored values taken while isolated reappear once the half is enabled;
- a mid-run reset empties the registers;
- the upper control bits are ignored in gang mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
    logic cap_ab;
    logic cap_ba;
  } half_ctrl_t;
endpackage

// File: rtl/xcvr_ctrl_sel.sv
module xcvr_ctrl_sel
  import xcvr_pkg::*;
#(
  parameter int NUM_HALVES = 2
) (
  input  logic                         gang_i,
  input  half_ctrl_t [NUM_HALVES-1:0]  ctrl_i,
  output half_ctrl_t [NUM_HALVES-1:0]  ctrl_o
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_sel
    if (h == 0) begin : g_lead
      assign ctrl_o[h] = ctrl_i[0];
    end else begin : g_follow
      assign ctrl_o[h] = gang_i ? ctrl_i[0] : ctrl_i[h];
    end
  end
endmodule

// File: rtl/xcvr_dir_dec.sv
module xcvr_dir_dec
  import xcvr_pkg::*;
(
  input  half_ctrl_t ctrl_i,
  output logic       a_oe_o,
  output logic       b_oe_o
);
  always_comb begin
    a_oe_o = 1'b0;
    b_oe_o = 1'b0;
    if (!ctrl_i.oe_n) begin
      if (ctrl_i.dir) b_oe_o = 1'b1;
      else            a_oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux #(
  parameter int WIDTH = 8
) (
  input  logic             en_i,
  input  logic             sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] y_o
);
  logic take_live, take_stored;

  // AND-OR form: each source gated by a decoded term, no chained mux
  assign take_live   = en_i & ~sel_i;
  assign take_stored = en_i &  sel_i;
  assign y_o = ({WIDTH{take_live}} & live_i) | ({WIDTH{take_stored}} & stored_i);
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter  int HALF_W     = 8,
  parameter  int NUM_HALVES = 2,
  localparam int BUS_W      = HALF_W * NUM_HALVES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  gang_i,
  input  logic [NUM_HALVES-1:0] oe_ni,
  input  logic [NUM_HALVES-1:0] dir_i,
  input  logic [NUM_HALVES-1:0] sel_ab_i,
  input  logic [NUM_HALVES-1:0] sel_ba_i,
  input  logic [NUM_HALVES-1:0] cap_ab_i,
  input  logic [NUM_HALVES-1:0] cap_ba_i,
  input  logic [BUS_W-1:0]      a_i,
  input  logic [BUS_W-1:0]      b_i,
  output logic [BUS_W-1:0]      a_o,
  output logic [NUM_HALVES-1:0] a_oe_o,
  output logic [BUS_W-1:0]      b_o,
  output logic [NUM_HALVES-1:0] b_oe_o
);
  half_ctrl_t [NUM_HALVES-1:0] raw_ctrl;
  half_ctrl_t [NUM_HALVES-1:0] eff_ctrl;
  logic [BUS_W-1:0] stored_ab;
  logic [BUS_W-1:0] stored_ba;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_pack
    assign raw_ctrl[h] = '{oe_n:   oe_ni[h],
                           dir:    dir_i[h],
                           sel_ab: sel_ab_i[h],
                           sel_ba: sel_ba_i[h],
                           cap_ab: cap_ab_i[h],
                           cap_ba: cap_ba_i[h]};
  end

  xcvr_ctrl_sel #(.NUM_HALVES(NUM_HALVES)) u_ctrl_sel (
    .gang_i (gang_i),
    .ctrl_i (raw_ctrl),
    .ctrl_o (eff_ctrl)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int LO = h * HALF_W;

    xcvr_dir_dec u_dec (
      .ctrl_i (eff_ctrl[h]),
      .a_oe_o (a_oe_o[h]),
      .b_oe_o (b_oe_o[h])
    );

    xcvr_store_reg #(.WIDTH(HALF_W)) u_reg_ab (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (eff_ctrl[h].cap_ab),
      .d_i    (a_i[LO +: HALF_W]),
      .q_o    (stored_ab[LO +: HALF_W])
    );

    xcvr_store_reg #(.WIDTH(HALF_W)) u_reg_ba (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (eff_ctrl[h].cap_ba),
      .d_i    (b_i[LO +: HALF_W]),
      .q_o    (stored_ba[LO +: HALF_W])
    );

    xcvr_out_mux #(.WIDTH(HALF_W)) u_mux_b (
      .en_i     (b_oe_o[h]),
      .sel_i    (eff_ctrl[h].sel_ab),
      .live_i   (a_i[LO +: HALF_W]),
      .stored_i (stored_ab[LO +: HALF_W]),
      .y_o      (b_o[LO +: HALF_W])
    );

    xcvr_out_mux #(.WIDTH(HALF_W)) u_mux_a (
      .en_i     (a_oe_o[h]),
      .sel_i    (eff_ctrl[h].sel_ba),
      .live_i   (b_i[LO +: HALF_W]),
      .stored_i (stored_ba[LO +: HALF_W]),
      .y_o      (a_o[LO +: HALF_W])
    );
  end
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter  int HALF_W     = 8,
  parameter  int NUM_HALVES = 2,
  localparam int BUS_W      = HALF_W * NUM_HALVES
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  gang_i,
  input logic [NUM_HALVES-1:0] oe_ni,
  input logic [NUM_HALVES-1:0] dir_i,
  input logic [NUM_HALVES-1:0] sel_ab_i,
  input logic [NUM_HALVES-1:0] sel_ba_i,
  input logic [NUM_HALVES-1:0] cap_ab_i,
  input logic [NUM_HALVES-1:0] cap_ba_i,
  input logic [BUS_W-1:0]      a_i,
  input logic [BUS_W-1:0]      b_i,
  input logic [BUS_W-1:0]      a_o,
  input logic [NUM_HALVES-1:0] a_oe_o,
  input logic [BUS_W-1:0]      b_o,
  input logic [NUM_HALVES-1:0] b_oe_o,
  input logic [BUS_W-1:0]      stored_ab,
  input logic [BUS_W-1:0]      stored_ba
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    localparam int LO = h * HALF_W;

    a_r4_oe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(a_oe_o[h] && b_oe_o[h]));

    a_r3_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gang_i && oe_ni[h]) |-> (!a_oe_o[h] && !b_oe_o[h]));

    a_r7_b_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !b_oe_o[h] |-> (b_o[LO +: HALF_W] == '0));

    a_r7_a_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !a_oe_o[h] |-> (a_o[LO +: HALF_W] == '0));

    a_r5_live_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gang_i && b_oe_o[h] && !sel_ab_i[h]) |-> (b_o[LO +: HALF_W] == a_i[LO +: HALF_W]));

    a_r6_live_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gang_i && a_oe_o[h] && !sel_ba_i[h]) |-> (a_o[LO +: HALF_W] == b_i[LO +: HALF_W]));

    a_r1_cap_ab: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gang_i && cap_ab_i[h]) |=> (stored_ab[LO +: HALF_W] == $past(a_i[LO +: HALF_W])));

    a_r1_cap_ba: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gang_i && cap_ba_i[h]) |=> (stored_ba[LO +: HALF_W] == $past(b_i[LO +: HALF_W])));

    a_r2_hold_ab: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gang_i && !cap_ab_i[h]) |=> $stable(stored_ab[LO +: HALF_W]));

    a_r2_hold_ba: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gang_i && !cap_ba_i[h]) |=> $stable(stored_ba[LO +: HALF_W]));

    a_r10_gang_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gang_i |-> (a_oe_o[h] == a_oe_o[0] && b_oe_o[h] == b_oe_o[0]));
  end
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gang_i    (gang_i),
  .oe_ni     (oe_ni),
  .dir_i     (dir_i),
  .sel_ab_i  (sel_ab_i),
  .sel_ba_i  (sel_ba_i),
  .cap_ab_i  (cap_ab_i),
  .cap_ba_i  (cap_ba_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .a_o       (a_o),
  .a_oe_o    (a_oe_o),
  .b_o       (b_o),
  .b_oe_o    (b_oe_o),
  .stored_ab (stored_ab),
  .stored_ba (stored_ba)
);

// File: tb/reg_bus_xcvr_tb_top.sv
module reg_bus_xcvr_tb_top;
  localparam int CLK_P = 10;
  localparam int HW    = 8;
  localparam int NH    = 2;
  localparam int BW    = HW * NH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gang = 1'b0;
  logic [NH-1:0] oe_n = '1, dir = '0, sab = '0, sba = '0, cab = '0, cba = '0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [BW-1:0] a_out, b_out;
  logic [NH-1:0] a_oe, b_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  string tag_force = "";

  logic [HW-1:0] m_ab [NH];
  logic [HW-1:0] m_ba [NH];

  always #(CLK_P/2) clk = ~clk;

  reg_bus_xcvr #(.HALF_W(HW), .NUM_HALVES(NH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gang_i(gang),
    .oe_ni(oe_n), .dir_i(dir), .sel_ab_i(sab), .sel_ba_i(sba),
    .cap_ab_i(cab), .cap_ba_i(cba), .a_i(a_in), .b_i(b_in),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(string req, logic [HW-1:0] act, logic [HW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string pick(int h, string base);
    if (tag_force != "") return tag_force;
    if (gang) return "R10";
    if (h != 0) return "R9";
    return base;
  endfunction

  task automatic check_all();
    for (int h = 0; h < NH; h++) begin
      int e = gang ? 0 : h;
      logic xb = !oe_n[e] && dir[e];
      logic xa = !oe_n[e] && !dir[e];
      logic [HW-1:0] eb = !xb ? '0 : (sab[e] ? m_ab[h] : a_in[h*HW +: HW]);
      logic [HW-1:0] ea = !xa ? '0 : (sba[e] ? m_ba[h] : b_in[h*HW +: HW]);
      chk(pick(h, "R3"), {7'd0, b_oe[h]}, {7'd0, xb});
      chk(pick(h, "R3"), {7'd0, a_oe[h]}, {7'd0, xa});
      chk(pick(h, "R4"), {7'd0, a_oe[h] & b_oe[h]}, 8'd0);
      chk(pick(h, xb ? "R5" : "R7"), b_out[h*HW +: HW], eb);
      chk(pick(h, xa ? "R6" : "R7"), a_out[h*HW +: HW], ea);
    end
  endtask

  task automatic model_edge();
    for (int h = 0; h < NH; h++) begin
      int e = gang ? 0 : h;
      if (cab[e]) m_ab[h] = a_in[h*HW +: HW];
      if (cba[e]) m_ba[h] = b_in[h*HW +: HW];
    end
  endtask

  task automatic step();
    #1;
    check_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic set_half(int h, logic [5:0] c);
    {oe_n[h], dir[h], sab[h], sba[h], cab[h], cba[h]} = c;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int h = 0; h < NH; h++) begin m_ab[h] = '0; m_ba[h] = '0; end
    repeat (2) @(negedge clk);
    // R2: reset state, stored paths read zero
    oe_n = '0; dir = '1; sab = '1;
    tag_force = "R2"; step();
    dir = '0; sba = '1; step();
    rst_n = 1'b1;
    @(negedge clk);
    step();

    // R1 and R2: capture then hold with inputs changed
    tag_force = "R1";
    oe_n = '1; cab = '1; cba = '1; a_in = 16'hA55A; b_in = 16'h3CC3; step();
    cab = '0; cba = '0; a_in = 16'h1234; b_in = 16'h5678; step();
    tag_force = "R2";
    oe_n = '0; dir = '1; sab = '1; step();
    dir = '0; sba = '1; step();

    // R8: capture while isolated, then read out
    tag_force = "R8";
    oe_n = '1; cab = '1; cba = '1; a_in = 16'h0F96; b_in = 16'hE17B; step();
    cab = '0; cba = '0; a_in = '0; b_in = '0;
    oe_n = '0; dir = '1; sab = '1; step();
    dir = '0; sba = '1; step();
    // R8: capture into the opposite register while the other bus is driven
    cba = '1; b_in = 16'h6D24; step();
    cba = '0; b_in = '0; step();
    tag_force = "";

    // exhaustive control sweep: half 0 combo, half 1 derived, gang both ways
    for (int k = 0; k < 128; k++) begin
      gang = k[6];
      set_half(0, k[5:0]);
      set_half(1, k[5:0] ^ 6'b101101);
      a_in = 16'(k * 16'h0B5D) ^ 16'h3C21;
      b_in = 16'(k * 16'h71A3) + 16'h0F0E;
      step();
    end

    // R2: asynchronous reset mid-run clears stored values
    gang = 0; cab = '1; cba = '1; oe_n = '1;
    a_in = 16'hBEEF; b_in = 16'hCAFE; step();
    cab = '0; cba = '0;
    rst_n = 1'b0;
    for (int h = 0; h < NH; h++) begin m_ab[h] = '0; m_ba[h] = '0; end
    #1;
    tag_force = "R2";
    oe_n = '0; dir = '1; sab = '1; step();
    dir = '0; sba = '1; step();
    rst_n = 1'b1;
    @(negedge clk);
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule